// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Buffer

This block is the record store of a logic-capture engine. Once armed, it writes a packed record into an on-chip RAM each time the upstream logic raises a write request. A write request comes from either a channel change or a timestamp rollover. Each record holds the timestamp of that moment and the channel sample.

Before the trigger, only a lower region of the memory is used, and it is used as a ring, so the most recent history is kept and older records are overwritten. The size of that region is a chosen share of the memory, set in tenths from one tenth to nine tenths. When the trigger arrives, writing moves on to the part of the memory above the ring and fills it in a straight line. When the last location is written, the block raises a done flag and stops accepting writes.

A control unit then pulls the records out one per read strobe. They come out in time order: the oldest record still held in the ring first, then around the ring, then every post-trigger record. Dropping the arm input abandons the capture and returns the block to idle. Raising it again starts a fresh capture.

Top module: `capture_store`

## Requirements
- R1: Each stored record is `{stampIn, sampleIn}`, with the timestamp in the upper STAMP_W bits, and it is read back unchanged.
- R2: The block enters capture one cycle after `armEn` rises. Write requests and trigger pulses presented while idle, including the arming cycle itself, are not stored and have no effect.
- R3: The ring holds floor(DEPTH × r / 10) records, where r is `preRatio` clamped to the range 1..9. The size is latched when capture starts, and later changes to `preRatio` have no effect on that capture.
- R4: A `trigHit` pulse during pre-trigger capture switches the block to post-trigger filling. A write in the same cycle as the trigger is stored as the newest pre-trigger record. Later trigger pulses are ignored.
- R5: After the trigger, exactly DEPTH − ringSize more writes are stored. `capDone` is high from the clock edge that stores the last of them.
- R6: While `capDone` is high, write requests are ignored and the stored records stay unchanged.
- R7: Readout starts one cycle after `capDone` rises. While `rdValid` is high, `rdData` holds the current record. A cycle with `rdStrobe` high moves to the next record at the following edge. The order is the oldest surviving ring record first, wrapping within the ring, followed by the post-trigger records in write order.
- R8: If the ring never filled before the trigger, readout starts at ring address 0 and yields only the records that were written, followed by the post-trigger records.
- R9: After the last record, `rdValid` stays low and further strobes are ignored.
- R10: Dropping `armEn` clears `capDone` and `rdValid` at the next edge, and a new arming starts a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armEn | input | 1 | Capture enable; low returns the block to idle |
| wrReq | input | 1 | Store a record this cycle (change or rollover) |
| sampleIn | input | DATA_W | Channel sample to store |
| stampIn | input | STAMP_W | Relative timestamp to store |
| trigHit | input | 1 | Trigger condition met |
| preRatio | input | RATIO_W | Ring share of depth, in tenths |
| rdStrobe | input | 1 | Advance to the next record |
| rdData | output | STAMP_W+DATA_W | Current record during readout |
| capDone | output | 1 | Memory is full and capture is complete |
| rdValid | output | 1 | `rdData` holds a record not yet consumed |

## Verification
Two functions can fall in the same cycle: the pre-trigger ring write and the switch to post-trigger filling, when `wrReq` and `trigHit` arrive together. The bench provokes this by raising the trigger on the final pre-trigger write, both when the ring has wrapped and when it is only partly filled. It judges the result by whether that record comes out as the last ring record, directly ahead of the first post-trigger record. A second overlap is a read strobe in the cycle where the next address is formed. Random read gaps check that `rdData` holds steady and that no record is skipped or repeated.

// File: rtl/capture_store_pkg.sv
package capture_store_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_PRE  = 2'd1,
    CS_POST = 2'd2,
    CS_DONE = 2'd3
  } capState_t;

  // Strobes from the control unit to the record datapath.
  typedef struct packed {
    logic wrEn;    // store the incoming record at wrAddr
    logic rdLoad;  // register the record at rdAddr onto rdData
  } pathStrobe_t;

endpackage

// File: rtl/capture_store_ratio.sv
module capture_store_ratio #(
  parameter int ADDR_W  = 6,
  parameter int RATIO_W = 4
) (
  input  logic [RATIO_W-1:0] ratioIn,
  output logic [ADDR_W:0]    regionSize
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int STEPS    = 1 << RATIO_W;
  localparam int MIN_STEP = 1;
  localparam int MAX_STEP = 9;
  localparam int STEP_DEN = 10;

  function automatic logic [ADDR_W:0] sizeFor(input int r);
    int rc;
    int prod;
    rc = r;
    if (rc < MIN_STEP) rc = MIN_STEP;
    if (rc > MAX_STEP) rc = MAX_STEP;
    prod = (DEPTH * rc) / STEP_DEN;
    if (prod < 1) prod = 1;
    if (prod > DEPTH - 1) prod = DEPTH - 1;
    return (ADDR_W + 1)'(prod);
  endfunction

  logic [ADDR_W:0] sizeTab [STEPS];

  // One constant entry per ratio code; the index selects it.
  for (genvar g = 0; g < STEPS; g++) begin : g_tab
    assign sizeTab[g] = sizeFor(g);
  end

  assign regionSize = sizeTab[ratioIn];

endmodule

// File: rtl/capture_store_path.sv
module capture_store_path import capture_store_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int STAMP_W = 8,
  parameter int ADDR_W  = 6
) (
  input  logic                      clk,
  input  pathStrobe_t               strobe,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [DATA_W-1:0]         sampleIn,
  input  logic [STAMP_W-1:0]        stampIn,
  output logic [STAMP_W+DATA_W-1:0] rdData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = STAMP_W + DATA_W;

  logic [WORD_W-1:0] recMem [DEPTH];
  logic [WORD_W-1:0] packedRec;

  assign packedRec = {stampIn, sampleIn};

  always_ff @(posedge clk) begin
    if (strobe.wrEn) recMem[wrAddr] <= packedRec;
    if (strobe.rdLoad) rdData <= recMem[rdAddr];
  end

endmodule

// File: rtl/capture_store_ctrl.sv
module capture_store_ctrl import capture_store_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armEn,
  input  logic              wrReq,
  input  logic              trigHit,
  input  logic              rdStrobe,
  input  logic [ADDR_W:0]   regionSize,
  output pathStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              capDone,
  output logic              rdValid
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0]  DEPTH_C   = CNT_W'(1 << ADDR_W);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  capState_t         state;
  logic [CNT_W-1:0]  sizeQ, fillCnt, rdIdx, rdIdxNext, totalRecs;
  logic [CNT_W-1:0]  ringSum, ringAdj, postOff;
  logic [ADDR_W-1:0] ringPtr, postPtr, ringStart;
  logic              wrEn, advance, ringWrapped;

  // Write side: ring pointer before the trigger, linear pointer after it.
  always_comb begin
    wrEn        = armEn && wrReq && (state == CS_PRE || state == CS_POST);
    wrAddr      = (state == CS_POST) ? postPtr : ringPtr;
    ringWrapped = (fillCnt == sizeQ);
  end

  // Read side: map the chronological index to a RAM address.
  always_comb begin
    ringStart = ringWrapped ? ringPtr : '0;
    totalRecs = fillCnt + (DEPTH_C - sizeQ);
    advance   = (state == CS_DONE) && rdValid && rdStrobe;
    rdIdxNext = (state == CS_DONE) ? rdIdx + CNT_W'(advance) : '0;
    ringSum   = {1'b0, ringStart} + rdIdxNext;
    ringAdj   = (ringSum >= sizeQ) ? ringSum - sizeQ : ringSum;
    postOff   = sizeQ + rdIdxNext - fillCnt;
    rdAddr    = (rdIdxNext < fillCnt) ? ringAdj[ADDR_W-1:0] : postOff[ADDR_W-1:0];
  end

  always_comb begin
    strobe.wrEn   = wrEn;
    strobe.rdLoad = (state == CS_DONE);
    capDone       = (state == CS_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= CS_IDLE;
      sizeQ   <= '0;
      fillCnt <= '0;
      ringPtr <= '0;
      postPtr <= '0;
    end else if (!armEn) begin
      state <= CS_IDLE;
    end else begin
      unique case (state)
        CS_IDLE: begin
          state   <= CS_PRE;
          sizeQ   <= regionSize;
          fillCnt <= '0;
          ringPtr <= '0;
          postPtr <= '0;
        end
        CS_PRE: begin
          if (wrReq) begin
            ringPtr <= ({1'b0, ringPtr} == sizeQ - CNT_W'(1)) ? '0 : ringPtr + 1'b1;
            if (fillCnt != sizeQ) fillCnt <= fillCnt + CNT_W'(1);
          end
          if (trigHit) begin
            state   <= CS_POST;
            postPtr <= sizeQ[ADDR_W-1:0];
          end
        end
        CS_POST: begin
          if (wrReq) begin
            if (postPtr == LAST_ADDR) state <= CS_DONE;
            else postPtr <= postPtr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx   <= '0;
      rdValid <= 1'b0;
    end else if (!armEn) begin
      rdIdx   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdIdx   <= rdIdxNext;
      rdValid <= (state == CS_DONE) && (rdIdxNext < totalRecs);
    end
  end

  // R3: a pre-trigger write never leaves the ring region.
  a_r3_ring_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == CS_PRE && wrEn) |-> ({1'b0, ringPtr} < sizeQ));

  // R8: the count of valid ring records never passes the ring size.
  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state != CS_IDLE) |-> (fillCnt <= sizeQ));

  // R4: a trigger in pre-trigger capture moves the block to post filling.
  a_r4_trigger_switch: assert property (@(posedge clk) disable iff (!rstN)
    (state == CS_PRE && armEn && trigHit) |=> (state == CS_POST));

  // R5: storing the last location completes the capture.
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (state == CS_POST && wrEn && postPtr == LAST_ADDR) |=> capDone);

  // R6: completion holds while armed.
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (capDone && armEn) |=> capDone);

  // R7: an accepted strobe advances the index by exactly one.
  a_r7_advance: assert property (@(posedge clk) disable iff (!rstN)
    (capDone && armEn && rdValid && rdStrobe) |=> (rdIdx == $past(rdIdx) + CNT_W'(1)));

  // R9: valid records only exist in the done state.
  a_r9_valid_in_done: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> capDone);

  // R10: disarming clears completion and readout.
  a_r10_disarm: assert property (@(posedge clk) disable iff (!rstN)
    !armEn |=> (!capDone && !rdValid));

endmodule

// File: rtl/capture_store.sv
module capture_store import capture_store_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int STAMP_W = 8,
  parameter int ADDR_W  = 6,
  parameter int RATIO_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      armEn,
  input  logic                      wrReq,
  input  logic [DATA_W-1:0]         sampleIn,
  input  logic [STAMP_W-1:0]        stampIn,
  input  logic                      trigHit,
  input  logic [RATIO_W-1:0]        preRatio,
  input  logic                      rdStrobe,
  output logic [STAMP_W+DATA_W-1:0] rdData,
  output logic                      capDone,
  output logic                      rdValid
);
  pathStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [ADDR_W:0]   regionSize;

  capture_store_ratio #(.ADDR_W(ADDR_W), .RATIO_W(RATIO_W)) u_ratio (
    .ratioIn(preRatio), .regionSize(regionSize)
  );

  capture_store_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .armEn(armEn), .wrReq(wrReq), .trigHit(trigHit),
    .rdStrobe(rdStrobe), .regionSize(regionSize), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .capDone(capDone), .rdValid(rdValid)
  );

  capture_store_path #(.DATA_W(DATA_W), .STAMP_W(STAMP_W), .ADDR_W(ADDR_W)) u_path (
    .clk(clk), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .sampleIn(sampleIn), .stampIn(stampIn), .rdData(rdData)
  );

endmodule

// File: tb/capture_store_bench.sv
`timescale 1ns/1ps
module capture_store_bench;
  localparam int DATA_W = 8, STAMP_W = 8, ADDR_W = 6, RATIO_W = 4;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORD_W = DATA_W + STAMP_W;

  logic clk = 1'b0, rstN = 1'b0, armEn = 1'b0, wrReq = 1'b0, trigHit = 1'b0, rdStrobe = 1'b0;
  logic [DATA_W-1:0]  sampleIn = '0;
  logic [STAMP_W-1:0] stampIn = '0;
  logic [RATIO_W-1:0] preRatio = '0;
  logic [WORD_W-1:0]  rdData;
  logic capDone, rdValid;

  int checkCnt = 0, failCnt = 0, cycleCnt = 0;
  logic [STAMP_W-1:0] stampCtr = '0;
  logic [WORD_W-1:0] preQ[$], postQ[$], expQ[$];

  always #4 clk = ~clk;

  capture_store #(.DATA_W(DATA_W), .STAMP_W(STAMP_W), .ADDR_W(ADDR_W), .RATIO_W(RATIO_W))
    u_capture_store (.clk(clk), .rstN(rstN), .armEn(armEn), .wrReq(wrReq),
      .sampleIn(sampleIn), .stampIn(stampIn), .trigHit(trigHit), .preRatio(preRatio),
      .rdStrobe(rdStrobe), .rdData(rdData), .capDone(capDone), .rdValid(rdValid));

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 100000) begin
      failCnt++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycleCnt);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int regionOf(input int r);
    int rc;
    rc = (r < 1) ? 1 : ((r > 9) ? 9 : r);
    return (DEPTH * rc) / 10;
  endfunction

  // One write cycle; returns the record the bench expects to be stored.
  task automatic doWrite(input bit trig, output logic [WORD_W-1:0] word);
    sampleIn = DATA_W'($urandom);
    stampIn  = stampCtr;
    stampCtr = stampCtr + 1'b1;
    word = {stampIn, sampleIn};
    wrReq = 1'b1; trigHit = trig;
    @(negedge clk);
    wrReq = 1'b0; trigHit = 1'b0;
  endtask

  task automatic idleGap(input bit gaps, input bit spurTrig);
    if (gaps && ($urandom % 3 == 0)) begin
      trigHit = spurTrig && ($urandom % 2 == 0);
      @(negedge clk);
      trigHit = 1'b0;
    end
  endtask

  task automatic doRun(input int ratio, input int nPre, input bit trigOnWrite,
                       input bit gaps, input string tag);
    int size;
    logic [WORD_W-1:0] w;
    preQ.delete(); postQ.delete(); expQ.delete();
    size = regionOf(ratio);
    preRatio = RATIO_W'(ratio);
    // R2: junk write and trigger in the arming cycle must be ignored.
    armEn = 1'b1; wrReq = 1'b1; trigHit = 1'b1; sampleIn = 8'hEE; stampIn = 8'hEE;
    @(negedge clk);
    wrReq = 1'b0; trigHit = 1'b0;
    chk(capDone == 1'b0 && rdValid == 1'b0, "R2 armed state", {capDone, rdValid}, 0);
    preRatio = RATIO_W'($urandom);  // R3: latched at arming, must not matter
    for (int i = 0; i < nPre; i++) begin
      idleGap(gaps, 1'b0);
      doWrite(trigOnWrite && (i == nPre - 1), w);
      preQ.push_back(w);
      if (preQ.size() > size) void'(preQ.pop_front());
    end
    if (!(trigOnWrite && nPre > 0)) begin
      trigHit = 1'b1; @(negedge clk); trigHit = 1'b0;
    end
    for (int i = 0; i < DEPTH - size; i++) begin
      if (i == DEPTH - size - 1)
        chk(capDone == 1'b0, "R5 not done before last write", capDone, 0);
      idleGap(gaps, 1'b1);
      doWrite(1'b0, w);
      postQ.push_back(w);
    end
    chk(capDone == 1'b1, "R5 done after last write", capDone, 1);
    for (int i = 0; i < 3; i++) doWrite(1'b0, w);  // R6: ignored
    chk(capDone == 1'b1, "R6 done holds", capDone, 1);
    foreach (preQ[i]) expQ.push_back(preQ[i]);
    foreach (postQ[i]) expQ.push_back(postQ[i]);
    for (int k = 0; k < expQ.size(); k++) begin
      chk(rdValid == 1'b1, {tag, " rdValid"}, rdValid, 1);
      chk(rdData == expQ[k], (k == 0) ? {tag, " R1 first record"} : {tag, " record order"},
          rdData, expQ[k]);
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        chk(rdData == expQ[k], "R7 hold without strobe", rdData, expQ[k]);
      end
      rdStrobe = 1'b1; @(negedge clk); rdStrobe = 1'b0;
    end
    chk(rdValid == 1'b0, "R9 end of records", rdValid, 0);
    rdStrobe = 1'b1; @(negedge clk); rdStrobe = 1'b0;
    chk(rdValid == 1'b0, "R9 strobe after end", rdValid, 0);
    armEn = 1'b0; @(negedge clk);
    chk(capDone == 1'b0 && rdValid == 1'b0, "R10 disarm", {capDone, rdValid}, 0);
    @(negedge clk);
  endtask

  initial begin
    logic [WORD_W-1:0] w;
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(capDone == 1'b0 && rdValid == 1'b0, "R10 reset state", {capDone, rdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2: activity while idle is ignored.
    wrReq = 1'b1; trigHit = 1'b1; @(negedge clk); wrReq = 1'b0; trigHit = 1'b0;
    chk(capDone == 1'b0 && rdValid == 1'b0, "R2 idle ignores input", {capDone, rdValid}, 0);

    doRun(5, 100, 1'b0, 1'b0, "R7 wrapped ring");
    doRun(1, 3, 1'b1, 1'b0, "R8 partial ring with trigger on write");
    doRun(9, 0, 1'b0, 1'b0, "R8 empty ring");
    doRun(3, 40, 1'b1, 1'b1, "R4 trigger on wrapped write");
    doRun(0, 20, 1'b0, 1'b1, "R3 ratio clamp low");
    doRun(15, 70, 1'b0, 1'b0, "R3 ratio clamp high");

    // R10: abort mid-capture, then a fresh capture must work.
    armEn = 1'b1; @(negedge clk);
    for (int i = 0; i < 5; i++) doWrite(1'b0, w);
    armEn = 1'b0; @(negedge clk);
    chk(capDone == 1'b0 && rdValid == 1'b0, "R10 abort", {capDone, rdValid}, 0);
    doRun(7, 12, 1'b0, 1'b1, "R10 rearm");

    for (int n = 0; n < 6; n++)
      doRun(int'($urandom % 16), int'($urandom % 90), 1'(($urandom % 2)), 1'b1, "R7 random");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule